// File: doc/BRIEF.md
# Floating-Point Deferred-Trap Queue Controller

This block is the control logic for a floating-point unit that reports arithmetic exceptions late. An FP operate instruction that raises an exception does not trap at once. The controller only records it and enters a pending state. The next FP operate, load or branch then takes the trap. At that point the faulting instruction's address and encoding go into a one-entry fault queue. While that queue holds an entry, most FP instructions are refused with a sequence-error trap. Only a privileged queue-store instruction can empty the queue. It hands out the saved entry as one 64-bit doubleword.

The integer pipeline presents at most one FP-related strobe per cycle. Each strobe comes with the instruction's address, encoding and next-PC. Each strobe is one of: operate, operate-with-exception, load, store, branch, status load and queue-store. The controller answers one cycle later. It gives a registered trap request with a trap code and the PC pair to report. It also gives the status fields and, after a successful queue-store, the queue doubleword. Arithmetic, register file, memory access and trap vectoring are outside this block.

Top module: `fp_defer_queue`

## Requirements
- R1: A synchronous active-high `rst` gives state execute (`fsmState`=0), queue flag 0, fault type 0, `trapReq`=0 and `qValid`=0.
- R2: An operate with `opExcept` set, in state execute with the queue empty and the FPU enabled, moves the controller to pending (`fsmState`=1). It raises no trap and latches that instruction's address and encoding.
- R3: In pending with the queue empty, an operate, load, branch or status load raises trap code 1 (FP exception) and enters state exception (`fsmState`=2). It sets the queue flag and copies the latched address and encoding into the queue. It reports `trapPc`=`nextPc` and `trapNpc`=`nextPc`+4. State exception always has the queue flag set.
- R4: While the queue flag is set, an operate, load, branch or status load raises trap code 1 and sets the fault type to 4 (sequence error). It moves to pending and leaves the queue contents unchanged. It reports `trapPc`=`instAddr` and `trapNpc`=`nextPc`.
- R5: An FP store with the FPU enabled never traps and changes neither the state nor the status fields, in any state.
- R6: A queue-store is checked in this order. A non-supervisor access gives code 3 (privilege). A disabled FPU gives code 2. Nonzero `memAlign` gives code 4 (alignment). An empty queue gives code 1 with fault type 4. A trapped queue-store leaves the queue and state untouched.
- R7: A queue-store that passes every check pulses `qValid` and presents `qWord` = {queue address, queue encoding}, with the address in bits 63:32. It clears the queue flag and returns to execute.
- R8: With `fpEnable` low, every FP class (operate, load, store, branch, status load) raises code 2. This check wins over the sequence-error check, and the state and status fields are unchanged.
- R9: `statWord` shows the queue flag at bit 13 and the fault type at bits 16:14, with all other bits zero. A status load that is not trapped writes `wrQne` and `wrFtt` into those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fpEnable | input | 1 | FPU enabled |
| isSuper | input | 1 | Current instruction runs in supervisor mode |
| doOp | input | 1 | FP operate (includes compares) strobe |
| opExcept | input | 1 | The operate signals an IEEE exception (with doOp) |
| doLoad | input | 1 | FP data load strobe |
| doStore | input | 1 | FP store strobe |
| doBranch | input | 1 | FP branch strobe |
| doQStore | input | 1 | Queue-store instruction strobe |
| statWr | input | 1 | FP status load strobe |
| wrQne | input | 1 | Queue flag value carried by the status load |
| wrFtt | input | 3 | Fault type value carried by the status load |
| memAlign | input | 2 | Low two bits of the queue-store effective address |
| instAddr | input | 32 | Address of the presented instruction |
| instWord | input | 32 | Encoding of the presented instruction |
| nextPc | input | 32 | Next-PC belonging to the presented instruction |
| trapReq | output | 1 | Trap request, registered, one cycle per trapped instruction |
| trapCode | output | 3 | 1 FP exception, 2 FP disabled, 3 privilege, 4 alignment |
| trapPc | output | 32 | PC to report with the last trap |
| trapNpc | output | 32 | Next-PC to report with the last trap |
| fsmState | output | 2 | 0 execute, 1 pending, 2 exception |
| statWord | output | 32 | Status view: bit 13 queue flag, bits 16:14 fault type |
| qValid | output | 1 | Queue doubleword valid for one cycle |
| qWord | output | 64 | Queue doubleword, address high, encoding low |

## Verification
The assertions assume that the pipeline presents at most one of the six instruction strobes in a cycle, and that `opExcept` only carries meaning alongside `doOp`. One of the assertions checks the first of these. The stimulus drives each case as a single strobe for exactly one cycle, followed by idle cycles. So the queue-store that drains the queue and every setup sequence respect the one-strobe-per-cycle rule. The sweep visits every instruction class with each combination of enable, privilege and address alignment. It does this from five starting conditions: execute, pending, exception, pending after a sequence error, and execute with the queue flag forced by a status load.

// File: rtl/fp_defer_pkg.sv
package fp_defer_pkg;

  typedef enum logic [1:0] {
    ST_EXEC = 2'd0,
    ST_PEND = 2'd1,
    ST_EXC  = 2'd2
  } fpState_e;

  typedef enum logic [2:0] {
    TR_NONE  = 3'd0,
    TR_FPEXC = 3'd1,
    TR_FPDIS = 3'd2,
    TR_PRIV  = 3'd3,
    TR_ALIGN = 3'd4
  } trapCode_e;

  localparam int FTT_W = 3;
  localparam int QNE_POS = 13;
  localparam int FTT_POS = 14;
  localparam logic [FTT_W-1:0] FTT_SEQ = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic holdCapture;  // latch the excepting operate
    logic queueLoad;    // move latched entry into the queue
    logic trapLoad;     // update the reported PC pair
    logic pcDefer;      // report next-PC pair instead of precise pair
    logic qEmit;        // drive queue doubleword out
  } dpStrobe_t;

endpackage

// File: rtl/fp_defer_ctrl.sv
module fp_defer_ctrl
  import fp_defer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fpEnable,
  input  logic             isSuper,
  input  logic             doOp,
  input  logic             opExcept,
  input  logic             doLoad,
  input  logic             doStore,
  input  logic             doBranch,
  input  logic             doQStore,
  input  logic             statWr,
  input  logic             wrQne,
  input  logic [FTT_W-1:0] wrFtt,
  input  logic [1:0]       memAlign,
  output fpState_e         state,
  output logic             qne,
  output logic [FTT_W-1:0] ftt,
  output logic             trapReq,
  output trapCode_e        trapCode,
  output logic             qValid,
  output dpStrobe_t        strb
);

  fpState_e nState;
  logic nQne, nTrap;
  logic [FTT_W-1:0] nFtt;
  trapCode_e nCode;
  logic seqClass, fpClass;

  assign seqClass = doOp | doLoad | doBranch | statWr;
  assign fpClass  = seqClass | doStore;

  always_comb begin
    nState = state;
    nQne   = qne;
    nFtt   = ftt;
    nTrap  = 1'b0;
    nCode  = TR_NONE;
    strb   = '0;
    if (doQStore) begin
      if (!isSuper) begin
        nTrap = 1'b1; nCode = TR_PRIV;
      end else if (!fpEnable) begin
        nTrap = 1'b1; nCode = TR_FPDIS;
      end else if (memAlign != 2'b00) begin
        nTrap = 1'b1; nCode = TR_ALIGN;
      end else if (!qne) begin
        nTrap = 1'b1; nCode = TR_FPEXC; nFtt = FTT_SEQ;
      end else begin
        strb.qEmit = 1'b1;
        nQne = 1'b0;
        nState = ST_EXEC;
      end
    end else if (fpClass && !fpEnable) begin
      nTrap = 1'b1; nCode = TR_FPDIS;
    end else if (seqClass && qne) begin
      nTrap = 1'b1; nCode = TR_FPEXC; nFtt = FTT_SEQ;
      nState = ST_PEND;
    end else if (seqClass && state == ST_PEND) begin
      nTrap = 1'b1; nCode = TR_FPEXC;
      nState = ST_EXC;
      nQne = 1'b1;
      strb.queueLoad = 1'b1;
      strb.pcDefer = 1'b1;
    end else if (statWr) begin
      nQne = wrQne;
      nFtt = wrFtt;
    end else if (doOp && opExcept && state == ST_EXEC) begin
      nState = ST_PEND;
      strb.holdCapture = 1'b1;
    end
    strb.trapLoad = nTrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_EXEC;
      qne      <= 1'b0;
      ftt      <= '0;
      trapReq  <= 1'b0;
      trapCode <= TR_NONE;
      qValid   <= 1'b0;
    end else begin
      state    <= nState;
      qne      <= nQne;
      ftt      <= nFtt;
      trapReq  <= nTrap;
      trapCode <= nCode;
      qValid   <= strb.qEmit;
    end
  end

  // input contract: one instruction strobe per cycle
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({doOp, doLoad, doStore, doBranch, doQStore, statWr}));

  p_pend_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && !qne && fpEnable && doOp && opExcept)
    |=> (state == ST_PEND && !trapReq));

  p_defer_trap_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PEND && !qne && fpEnable && seqClass)
    |=> (trapReq && trapCode == TR_FPEXC && qne && state == ST_EXC));

  p_exc_has_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXC) |-> qne);

  p_seq_error_r4: assert property (@(posedge clk) disable iff (rst)
    (qne && fpEnable && seqClass)
    |=> (trapCode == TR_FPEXC && ftt == FTT_SEQ && state == ST_PEND && qne));

  p_store_free_r5: assert property (@(posedge clk) disable iff (rst)
    (doStore && fpEnable) |=> (!trapReq && $stable(qne) && $stable(ftt) && $stable(state)));

  p_qstore_priv_r6: assert property (@(posedge clk) disable iff (rst)
    (doQStore && !isSuper) |=> (trapReq && trapCode == TR_PRIV && !qValid));

  p_qstore_ok_r7: assert property (@(posedge clk) disable iff (rst)
    (doQStore && isSuper && fpEnable && memAlign == 2'b00 && qne)
    |=> (qValid && !qne && !trapReq && state == ST_EXEC));

  p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    (fpClass && !fpEnable) |=> (trapCode == TR_FPDIS && $stable(qne) && $stable(state)));

endmodule

// File: rtl/fp_defer_dpath.sv
module fp_defer_dpath
  import fp_defer_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  dpStrobe_t     strb,
  input  logic [AW-1:0] instAddr,
  input  logic [IW-1:0] instWord,
  input  logic [AW-1:0] nextPc,
  output logic [AW-1:0] trapPc,
  output logic [AW-1:0] trapNpc,
  output logic [AW+IW-1:0] qWord
);

  localparam logic [AW-1:0] INST_BYTES = AW'(4);

  logic [AW-1:0] holdAddr, qAddr;
  logic [IW-1:0] holdWord, qInsn;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdAddr <= '0;
      holdWord <= '0;
      qAddr    <= '0;
      qInsn    <= '0;
      trapPc   <= '0;
      trapNpc  <= '0;
      qWord    <= '0;
    end else begin
      if (strb.holdCapture) begin
        holdAddr <= instAddr;
        holdWord <= instWord;
      end
      if (strb.queueLoad) begin
        qAddr <= holdAddr;
        qInsn <= holdWord;
      end
      if (strb.trapLoad) begin
        trapPc  <= strb.pcDefer ? nextPc : instAddr;
        trapNpc <= strb.pcDefer ? nextPc + INST_BYTES : nextPc;
      end
      if (strb.qEmit) qWord <= {qAddr, qInsn};
    end
  end

  p_emit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.qEmit |=> $stable(qWord));

  p_queue_steady_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.queueLoad |=> ($stable(qAddr) && $stable(qInsn)));

endmodule

// File: rtl/fp_defer_queue.sv
module fp_defer_queue
  import fp_defer_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int SW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fpEnable,
  input  logic             isSuper,
  input  logic             doOp,
  input  logic             opExcept,
  input  logic             doLoad,
  input  logic             doStore,
  input  logic             doBranch,
  input  logic             doQStore,
  input  logic             statWr,
  input  logic             wrQne,
  input  logic [2:0]       wrFtt,
  input  logic [1:0]       memAlign,
  input  logic [AW-1:0]    instAddr,
  input  logic [IW-1:0]    instWord,
  input  logic [AW-1:0]    nextPc,
  output logic             trapReq,
  output logic [2:0]       trapCode,
  output logic [AW-1:0]    trapPc,
  output logic [AW-1:0]    trapNpc,
  output logic [1:0]       fsmState,
  output logic [SW-1:0]    statWord,
  output logic             qValid,
  output logic [AW+IW-1:0] qWord
);

  fpState_e   state;
  trapCode_e  code;
  logic       qne;
  logic [FTT_W-1:0] ftt;
  dpStrobe_t  strb;

  fp_defer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .fpEnable(fpEnable), .isSuper(isSuper),
    .doOp(doOp), .opExcept(opExcept), .doLoad(doLoad), .doStore(doStore),
    .doBranch(doBranch), .doQStore(doQStore), .statWr(statWr),
    .wrQne(wrQne), .wrFtt(wrFtt), .memAlign(memAlign),
    .state(state), .qne(qne), .ftt(ftt), .trapReq(trapReq),
    .trapCode(code), .qValid(qValid), .strb(strb)
  );

  fp_defer_dpath #(.AW(AW), .IW(IW)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .instAddr(instAddr),
    .instWord(instWord), .nextPc(nextPc), .trapPc(trapPc),
    .trapNpc(trapNpc), .qWord(qWord)
  );

  assign trapCode = code;
  assign fsmState = state;

  always_comb begin
    statWord = '0;
    statWord[QNE_POS] = qne;
    statWord[FTT_POS +: FTT_W] = ftt;
  end

  p_status_view_r9: assert property (@(posedge clk) disable iff (rst)
    (statWr && fpEnable && !qne && fsmState == 2'd0)
    |=> (statWord[QNE_POS] == $past(wrQne) && statWord[FTT_POS +: FTT_W] == $past(wrFtt)));

endmodule

// File: tb/tb_fp_defer_queue.sv
`timescale 1ns/1ps
module tb_fp_defer_queue;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fpEnable = 1'b1, isSuper = 1'b1;
  logic doOp = 0, opExcept = 0, doLoad = 0, doStore = 0, doBranch = 0, doQStore = 0, statWr = 0;
  logic wrQne = 0;
  logic [2:0] wrFtt = '0;
  logic [1:0] memAlign = '0;
  logic [31:0] instAddr = '0, instWord = '0, nextPc = '0;
  logic trapReq, qValid;
  logic [2:0] trapCode;
  logic [31:0] trapPc, trapNpc, statWord;
  logic [1:0] fsmState;
  logic [63:0] qWord;

  fp_defer_queue dut (
    .clk(clk), .rst(rst), .fpEnable(fpEnable), .isSuper(isSuper),
    .doOp(doOp), .opExcept(opExcept), .doLoad(doLoad), .doStore(doStore),
    .doBranch(doBranch), .doQStore(doQStore), .statWr(statWr),
    .wrQne(wrQne), .wrFtt(wrFtt), .memAlign(memAlign),
    .instAddr(instAddr), .instWord(instWord), .nextPc(nextPc),
    .trapReq(trapReq), .trapCode(trapCode), .trapPc(trapPc), .trapNpc(trapNpc),
    .fsmState(fsmState), .statWord(statWord), .qValid(qValid), .qWord(qWord)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0, k = 0;
  bit finished = 0;

  // behavioural expectation
  bit [1:0] mState; bit mQne; bit [2:0] mFtt;
  bit [31:0] mHA, mHW, mQA, mQW, mPc, mNpc;
  bit mTrap, mQV; bit [2:0] mCode; bit [63:0] mQO;
  string tag;

  function automatic bit [31:0] expStat();
    return (32'(mFtt) << 14) | (32'(mQne) << 13);
  endfunction

  task automatic modelReset();
    mState = 0; mQne = 0; mFtt = 0; mHA = 0; mHW = 0; mQA = 0; mQW = 0;
    mPc = 0; mNpc = 0; mTrap = 0; mQV = 0; mCode = 0; mQO = 0;
  endtask

  task automatic precise(input bit [2:0] c);
    mTrap = 1; mCode = c; mPc = instAddr; mNpc = nextPc;
  endtask

  task automatic modelStep();
    bit seqC, fpC;
    seqC = doOp | doLoad | doBranch | statWr;
    fpC = seqC | doStore;
    mTrap = 0; mCode = 0; mQV = 0; tag = "R2";
    if (doQStore) begin
      tag = "R6";
      if (!isSuper) precise(3);
      else if (!fpEnable) precise(2);
      else if (memAlign != 0) precise(4);
      else if (!mQne) begin precise(1); mFtt = 4; end
      else begin tag = "R7"; mQV = 1; mQO = {mQA, mQW}; mQne = 0; mState = 0; end
    end else if (fpC && !fpEnable) begin
      tag = "R8"; precise(2);
    end else if (seqC && mQne) begin
      tag = "R4"; precise(1); mFtt = 4; mState = 1;
    end else if (seqC && mState == 1) begin
      tag = "R3"; mTrap = 1; mCode = 1; mState = 2; mQne = 1;
      mQA = mHA; mQW = mHW; mPc = nextPc; mNpc = nextPc + 4;
    end else if (statWr) begin
      tag = "R9"; mQne = wrQne; mFtt = wrFtt;
    end else if (doOp && opExcept && mState == 0) begin
      mState = 1; mHA = instAddr; mHW = instWord;
    end else if (doStore) tag = "R5";
  endtask

  task automatic compare(input string t);
    nChecks++;
    if ({trapReq, trapCode, trapPc, trapNpc, fsmState, statWord, qValid, qWord} !==
        {mTrap, mCode, mPc, mNpc, mState, expStat(), mQV, mQO}) begin
      nFails++;
      $display("FAIL %s: actual trap=%0b code=%0d pc=%h npc=%h st=%0d stat=%h qv=%0b q=%h expected trap=%0b code=%0d pc=%h npc=%h st=%0d stat=%h qv=%0b q=%h",
        t, trapReq, trapCode, trapPc, trapNpc, fsmState, statWord, qValid, qWord,
        mTrap, mCode, mPc, mNpc, mState, expStat(), mQV, mQO);
    end
  endtask

  // cls: 0 idle 1 op 2 op+exc 3 load 4 store 5 branch 6 status load 7 queue-store
  task automatic step(input int cls, input bit en, input bit sup, input bit [1:0] al,
                      input bit wq, input bit [2:0] wf);
    k++;
    fpEnable = en; isSuper = sup; memAlign = al; wrQne = wq; wrFtt = wf;
    instAddr = 32'h4000_0000 + 32'(k) * 4;
    instWord = 32'(k) * 32'h9E37_79B9;
    nextPc = instAddr + (k[0] ? 32'd8 : 32'd4);
    doOp = (cls == 1 || cls == 2); opExcept = (cls == 2);
    doLoad = (cls == 3); doStore = (cls == 4); doBranch = (cls == 5);
    statWr = (cls == 6); doQStore = (cls == 7);
    modelStep();
    @(negedge clk);
    compare(tag);
    {doOp, opExcept, doLoad, doStore, doBranch, statWr, doQStore} = '0;
  endtask

  task automatic doReset();
    rst = 1;
    @(negedge clk);
    rst = 0;
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R1: watchdog expired, actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1: reset state
    compare("R1");
    for (int s = 0; s < 5; s++)
      for (int cls = 0; cls < 8; cls++)
        for (int en = 0; en < 2; en++)
          for (int sup = 0; sup < 2; sup++)
            for (int al = 0; al < 4; al++) begin
              doReset();
              compare("R1");
              case (s)
                1: step(2, 1, 1, 0, 0, 0);
                2: begin step(2, 1, 1, 0, 0, 0); step(1, 1, 1, 0, 0, 0); end
                3: begin step(2, 1, 1, 0, 0, 0); step(1, 1, 1, 0, 0, 0); step(3, 1, 1, 0, 0, 0); end
                4: step(6, 1, 1, 0, 1, 3'd5);
                default: ;
              endcase
              step(cls, en[0], sup[0], al[1:0], al[0], 3'(al + 1));
              step(0, 1, 1, 0, 0, 0);
              step(7, 1, 1, 0, 0, 0);   // drain: R7 queue contents / R6 empty
              step(5, 1, 1, 0, 0, 0);
            end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule